// File: doc/BRIEF.md
# Timer Count-Enable Source Selector

This block decides when an 8-bit timer/counter advances. It drives a one-cycle count-enable strobe. A 3-bit select code picks the source of that strobe. The source can be nothing, every system clock cycle, one of four taps of a shared divider, or a synchronized external pin. For the pin, the code also chooses whether rising or falling edges count.

The divider is a free-running 10-bit counter. It never stops and never restarts when the select code changes. For this reason, the first strobe after the timer is started from a divided source can arrive at any point inside one divider period. A one-cycle clear strobe puts the divider back to zero, so software can line up timer counting with a known moment.

The external pin passes through a two-stage synchronizer and then an edge-history register. The history register is always updated, whatever source is selected. As a result, a switch onto an external source never sees an edge that is out of date.

Top module: `tcs_clock_select`

## Requirements
- R1: With select code 0 the strobe `cnt_en_o` stays low, whatever the pin and the divider do.
- R2: With select code 1 the strobe is high in every cycle that follows a clock edge at which the code was 1.
- R3: Select codes 2, 3, 4 and 5 choose divide-by-8, 64, 256 and 1024. While the code is held, the strobe is one cycle wide and repeats every N cycles.
- R4: The clock edge that samples `presc_clr_i` high clears the divider. With a divided source held, the strobe then rises exactly N edges after that edge, and again every N edges.
- R5: A change of select code neither clears nor pauses the divider. After a switch between taps, the strobes of the new tap stay aligned to the last divider clear.
- R6: After a move from code 0 to a divided code, the first strobe arrives 1 to N+1 cycles after the change.
- R7: With code 7, a low-to-high pin change made between clock edges gives one strobe, exactly three edges later. A high-to-low change gives no strobe.
- R8: With code 6, a high-to-low pin change gives one strobe, exactly three edges later. A low-to-high change gives no strobe.
- R9: The edge history follows the pin under every select code. Switching to code 6 or 7 while the pin is steady gives no strobe.
- R10: While `rst_n` is low, the strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| src_sel_i | input | 3 | Count source code (0 off, 1 system clock, 2-5 divider taps, 6 pin falling, 7 pin rising) |
| presc_clr_i | input | 1 | One-cycle clear of the shared divider |
| ext_pin_i | input | 1 | Raw asynchronous external count pin |
| cnt_en_o | output | 1 | One-cycle count-enable strobe |

## Verification
The assertions check four things on every cycle: the strobe is quiet under code 0, it is high every cycle under code 1, a held divider tap never gives two strobes in a row, and a held pin source never gives two strobes in a row. The bench scenarios cover what needs a reference point in time. These are the exact period and phase of each tap after a clear, alignment that survives a tap switch, the allowed latency window for the first count, the exact three-edge pin latency for each polarity, and the absence of a strobe when switching onto a steady pin.

// File: rtl/tcs_pkg.sv
// Shared definitions for the timer count-source selector.
// Assumes the divider taps are powers of two, listed from smallest to largest.
package tcs_pkg;
    typedef enum logic [2:0] {
        SRC_OFF      = 3'd0,
        SRC_SYS      = 3'd1,
        SRC_DIV_A    = 3'd2,
        SRC_DIV_B    = 3'd3,
        SRC_DIV_C    = 3'd4,
        SRC_DIV_D    = 3'd5,
        SRC_PIN_FALL = 3'd6,
        SRC_PIN_RISE = 3'd7
    } src_sel_e;

    localparam int TAP_CNT = 4;
    localparam int TAP_LOG2 [TAP_CNT] = '{3, 6, 8, 10};
    localparam int PRESC_W = TAP_LOG2[TAP_CNT-1];
    localparam int SYNC_STAGES = 2;
endpackage

// File: rtl/tcs_prescaler.sv
// Free-running shared divider with power-of-two taps.
// Each tap is high for one cycle whenever the low bits of the counter are all ones,
// which is the cycle just before the counter wraps past a multiple of that divisor.
// Assumes the clear input is synchronous to clk and one cycle wide.
module tcs_prescaler
    import tcs_pkg::*;
#(
    parameter int CNT_W = PRESC_W,
    parameter int N_TAPS = TAP_CNT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    output logic [N_TAPS-1:0] tap_o
);
    logic [CNT_W-1:0] cnt_q;

    // Count up every cycle; a clear strobe or reset returns to zero.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) cnt_q <= '0;
        else                 cnt_q <= cnt_q + 1'b1;
    end

    // One tap per divisor, each watching its own slice of the counter.
    for (genvar g = 0; g < N_TAPS; g++) begin : g_tap
        assign tap_o[g] = &cnt_q[TAP_LOG2[g]-1:0];
    end
endmodule

// File: rtl/tcs_pin_sync.sv
// Brings the raw external pin into the clock domain and flags its edges.
// The synchronizer is a flop chain. A history flop that is always updated
// gives single-cycle rise and fall flags.
// Assumes the pin holds each level for at least two clock cycles.
module tcs_pin_sync
    import tcs_pkg::*;
#(
    parameter int STAGES = SYNC_STAGES
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic rise_o,
    output logic fall_o
);
    logic [STAGES-1:0] sync_q;
    logic              hist_q;
    logic              pin_s;

    assign pin_s = sync_q[STAGES-1];

    // Shift the pin through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[STAGES-2:0], pin_i};
    end

    // Remember the previous synchronized level under every select code.
    always_ff @(posedge clk) begin
        if (!rst_n) hist_q <= 1'b0;
        else        hist_q <= pin_s;
    end

    assign rise_o =  pin_s & ~hist_q;
    assign fall_o = ~pin_s &  hist_q;
endmodule

// File: rtl/tcs_src_mux.sv
// Combinational choice of the next strobe value from the select code.
// Assumes the tap vector is ordered like select codes SRC_DIV_A upward.
module tcs_src_mux
    import tcs_pkg::*;
#(
    parameter int N_TAPS = TAP_CNT
) (
    input  logic [2:0]        sel_i,
    input  logic [N_TAPS-1:0] tap_i,
    input  logic              rise_i,
    input  logic              fall_i,
    output logic              en_o
);
    // Decode the code into the matching source bit.
    always_comb begin
        en_o = 1'b0;
        if (sel_i == SRC_SYS)      en_o = 1'b1;
        if (sel_i == SRC_PIN_RISE) en_o = rise_i;
        if (sel_i == SRC_PIN_FALL) en_o = fall_i;
        for (int i = 0; i < N_TAPS; i++) begin
            if (sel_i == 3'(int'(SRC_DIV_A) + i)) en_o = tap_i[i];
        end
    end
endmodule

// File: rtl/tcs_clock_select.sv
// Top of the timer count-source selector. It joins the shared divider, the pin
// synchronizer and the source decode, then registers the result into a clean
// one-cycle count-enable strobe.
// Assumes the select code and the clear input are synchronous to clk.
module tcs_clock_select
    import tcs_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] src_sel_i,
    input  logic       presc_clr_i,
    input  logic       ext_pin_i,
    output logic       cnt_en_o
);
    logic [TAP_CNT-1:0] taps;
    logic               pin_rise;
    logic               pin_fall;
    logic               en_d;
    logic               en_q;

    tcs_prescaler #(.CNT_W(PRESC_W), .N_TAPS(TAP_CNT)) i_presc (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (presc_clr_i),
        .tap_o (taps)
    );

    tcs_pin_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  (ext_pin_i),
        .rise_o (pin_rise),
        .fall_o (pin_fall)
    );

    tcs_src_mux #(.N_TAPS(TAP_CNT)) i_mux (
        .sel_i  (src_sel_i),
        .tap_i  (taps),
        .rise_i (pin_rise),
        .fall_i (pin_fall),
        .en_o   (en_d)
    );

    // Register the selected source so the strobe is free of decode glitches.
    always_ff @(posedge clk) begin
        if (!rst_n) en_q <= 1'b0;
        else        en_q <= en_d;
    end

    assign cnt_en_o = en_q;
endmodule

// File: rtl/tcs_clock_select_chk.sv
// Port-level checker for the count-source selector, bound to every instance.
module tcs_clock_select_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] src_sel_i,
    input logic       cnt_en_o
);
    // R1: code 0 keeps the strobe quiet on the next cycle
    a_r1_stop_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (src_sel_i == 3'd0) |=> !cnt_en_o);

    // R2: code 1 strobes on the following cycle
    a_r2_every_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (src_sel_i == 3'd1) |=> cnt_en_o);

    // R3: a held divider tap never strobes two cycles running
    a_r3_tap_single: assert property (@(posedge clk) disable iff (!rst_n)
        (src_sel_i inside {[3'd2:3'd5]} && $past(src_sel_i) inside {[3'd2:3'd5]} && cnt_en_o)
        |=> !cnt_en_o);

    // R7: held rising-edge source never strobes two cycles running
    a_r7_rise_single: assert property (@(posedge clk) disable iff (!rst_n)
        (src_sel_i == 3'd7 && $past(src_sel_i) == 3'd7 && cnt_en_o) |=> !cnt_en_o);

    // R8: held falling-edge source never strobes two cycles running
    a_r8_fall_single: assert property (@(posedge clk) disable iff (!rst_n)
        (src_sel_i == 3'd6 && $past(src_sel_i) == 3'd6 && cnt_en_o) |=> !cnt_en_o);
endmodule

bind tcs_clock_select tcs_clock_select_chk i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .src_sel_i (src_sel_i),
    .cnt_en_o  (cnt_en_o)
);

// File: tb/test_tcs_clock_select.sv
// Directed bench: one task per scenario, each checking its own results.
// Inputs change and outputs are sampled at the falling clock edge.
module test_tcs_clock_select;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] src_sel_i = 3'd0;
    logic       presc_clr_i = 1'b0;
    logic       ext_pin_i = 1'b0;
    logic       cnt_en_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    tcs_clock_select i_tcs_clock_select (
        .clk         (clk),
        .rst_n       (rst_n),
        .src_sel_i   (src_sel_i),
        .presc_clr_i (presc_clr_i),
        .ext_pin_i   (ext_pin_i),
        .cnt_en_o    (cnt_en_o)
    );

    always #10 clk = ~clk;

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        src_sel_i = 3'd1;
        repeat (3) tick();
        check("R10 strobe low in reset", cnt_en_o, 0);
        src_sel_i = 3'd0;
        rst_n = 1'b1;
        tick();
    endtask

    task automatic t_stopped();
        src_sel_i = 3'd0;
        tick();
        for (int k = 0; k < 200; k++) begin
            check("R1 code 0 quiet", cnt_en_o, 0);
            ext_pin_i = k[2];
            presc_clr_i = (k == 50);
            tick();
        end
        presc_clr_i = 1'b0;
        ext_pin_i = 1'b0;
    endtask

    task automatic t_sysclk();
        src_sel_i = 3'd1;
        for (int k = 1; k <= 20; k++) begin
            tick();
            check("R2 code 1 every cycle", cnt_en_o, 1);
        end
        src_sel_i = 3'd0;
        tick();
    endtask

    // Clear the divider with a tap held, then check period and phase.
    task automatic t_tap(input logic [2:0] code, input int div);
        src_sel_i = code;
        tick();
        presc_clr_i = 1'b1;
        tick();
        presc_clr_i = 1'b0;
        for (int k = 1; k <= 2 * div; k++) begin
            tick();
            check((k == div) ? "R4 first strobe after clear" : "R3 tap period",
                  cnt_en_o, (k % div == 0) ? 1 : 0);
        end
        src_sel_i = 3'd0;
        tick();
    endtask

    // Switch from the /8 tap to the /64 tap after a clear; alignment must hold.
    task automatic t_switch();
        src_sel_i = 3'd2;
        tick();
        presc_clr_i = 1'b1;
        tick();
        presc_clr_i = 1'b0;
        for (int k = 1; k <= 130; k++) begin
            tick();
            if (k <= 20) check("R5 before switch", cnt_en_o, (k % 8 == 0) ? 1 : 0);
            else         check("R5 after switch", cnt_en_o, (k % 64 == 0) ? 1 : 0);
            if (k == 20) src_sel_i = 3'd3;
        end
        src_sel_i = 3'd0;
        tick();
    endtask

    // Start a divided source from code 0 at several phases and time the first strobe.
    task automatic t_latency(input logic [2:0] code, input int div, input int skew);
        int lat;
        src_sel_i = 3'd0;
        repeat (skew + 2) tick();
        src_sel_i = code;
        lat = 0;
        for (int k = 1; k <= div + 2; k++) begin
            tick();
            if (cnt_en_o && lat == 0) lat = k;
        end
        check("R6 first count not before 1 cycle", (lat >= 1) ? 1 : 0, 1);
        check("R6 first count within N+1", (lat <= div + 1) ? 1 : 0, 1);
        src_sel_i = 3'd0;
        tick();
    endtask

    // Drive a pin change and expect a strobe at edge 'want' (0 means none).
    task automatic pin_edge(input string tag, input logic lvl, input int want);
        ext_pin_i = lvl;
        for (int k = 1; k <= 6; k++) begin
            tick();
            check(tag, cnt_en_o, (k == want) ? 1 : 0);
        end
    endtask

    task automatic t_ext_rise();
        ext_pin_i = 1'b0;
        src_sel_i = 3'd7;
        repeat (5) tick();
        pin_edge("R7 rising counted after 3 edges", 1'b1, 3);
        pin_edge("R7 falling ignored", 1'b0, 0);
        pin_edge("R7 second rising", 1'b1, 3);
        ext_pin_i = 1'b0;
        repeat (4) tick();
    endtask

    task automatic t_ext_fall();
        ext_pin_i = 1'b1;
        src_sel_i = 3'd6;
        repeat (5) tick();
        pin_edge("R8 falling counted after 3 edges", 1'b0, 3);
        pin_edge("R8 rising ignored", 1'b1, 0);
        pin_edge("R8 second falling", 1'b0, 3);
    endtask

    // Pin steady during an internal source, then switch to the pin source.
    task automatic t_stale();
        ext_pin_i = 1'b1;
        src_sel_i = 3'd1;
        repeat (6) tick();
        src_sel_i = 3'd7;
        for (int k = 1; k <= 6; k++) begin
            tick();
            check("R9 no stale rising strobe", cnt_en_o, 0);
        end
        ext_pin_i = 1'b0;
        src_sel_i = 3'd0;
        repeat (6) tick();
        src_sel_i = 3'd6;
        for (int k = 1; k <= 6; k++) begin
            tick();
            check("R9 no stale falling strobe", cnt_en_o, 0);
        end
        src_sel_i = 3'd0;
        tick();
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_stopped();
        t_sysclk();
        t_tap(3'd2, 8);
        t_tap(3'd3, 64);
        t_tap(3'd4, 256);
        t_tap(3'd5, 1024);
        t_switch();
        t_latency(3'd2, 8, 3);
        t_latency(3'd3, 64, 17);
        t_latency(3'd4, 256, 101);
        t_latency(3'd5, 1024, 555);
        t_ext_rise();
        t_ext_fall();
        t_stale();
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule